// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block sits beside the CPU core of an 8-bit controller. It decides when the chip is running, idling, powered down or under control of an external emulator. It filters the reset pin into a clean internal reset. It gates the CPU and peripheral clocks and the oscillator enable. It also tells the pad ring how the bus strobes and ports behave in each mode.

Software requests idle or power down with a one-cycle strobe. Idle keeps the oscillator and peripherals alive and waits for any enabled interrupt. Power down stops the oscillator. Two things wake the chip from power down. The first is a reset. The second is an external interrupt line that is enabled and set to level sensing. Holding that line low restarts the oscillator. Releasing it completes the exit, once a stabilization count has run out.

The emulation mode is entered by strapping the address-latch strobe low during reset. In this mode the chip releases the bus so that a test processor can drive the board.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `int_rst` rises on the RST_MC*CYC_LEN-th consecutive rising edge (24 by default) at which `rst_pin` is sampled high while the oscillator is enabled. A shorter high pulse has no effect. `int_rst` falls on the first edge at which `rst_pin` is sampled low.
- R2: An `idle_req` strobe in the run state enters idle at the next edge. In idle, `cpu_clk_en`=0 while `periph_clk_en`=1 and `osc_en`=1. When `pd_req` and `idle_req` arrive together, power down wins.
- R3: Idle returns to run at the next edge when `irq_pend & irq_en` is nonzero. A pending interrupt whose enable bit is clear leaves the block in idle.
- R4: A `pd_req` strobe enters power down at the next edge. In power down, `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0. Ordinary interrupts do not wake it. An external line wakes it only when its `ext_en` and `ext_lvl` bits are both 1 and `ext_int_n` is low.
- R5: A qualifying low external line sets `osc_en` at the next edge. The block returns to run at the first edge at which no qualifying line is low and STAB_CYC edges have elapsed since the wake edge.
- R6: `ale_mode` and `psen_mode` use this encoding: 00 normal, 01 forced high, 10 forced low, 11 weak pull-up. Run uses 00, idle 01, every power-down state 10, and emulation 11.
- R7: With `ext_code`=1, `p0_float` is 1 in idle and in power down, and `p2_addr` is 1 in idle only. With `ext_code`=0, both are 0 in those modes.
- R8: If a qualified reset is released while `ale_in` is low, and `ale_in` was low with `psen_in` high on the last reset cycle, `emu_active` sets on the release edge. While it is set, `ale_mode`=11, `p0_float`=1, `ports_weak`=1 and the oscillator keeps running. Idle and power-down requests are ignored. A reset released with `ale_in` high clears it.
- R9: While idle and `rst_pin` is high, `ram_wr_block` is 1 until `int_rst` rises.
- R10: `rst_pin` high in power down sets `osc_en` at the next edge. Qualification then counts from the following edge, and the block enters run one edge after `int_rst` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Sampled external reset pin, active high |
| idle_req | input | 1 | Software idle request strobe |
| pd_req | input | 1 | Software power-down request strobe |
| irq_pend | input | NIRQ | Interrupt pending flags |
| irq_en | input | NIRQ | Interrupt enable flags |
| ext_int_n | input | NEXT | External interrupt pins, active low |
| ext_en | input | NEXT | External interrupt enables |
| ext_lvl | input | NEXT | 1 = line is level sensitive |
| ext_code | input | 1 | Code is fetched from external memory |
| ale_in | input | 1 | Sampled level of the address-latch strobe pin |
| psen_in | input | 1 | Sampled level of the program-read strobe pin |
| cpu_clk_en | output | 1 | CPU clock gate |
| periph_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Qualified internal reset |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| ale_mode | output | 2 | Address-latch strobe pad mode |
| psen_mode | output | 2 | Program-read strobe pad mode |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_addr | output | 1 | Port 2 drives the address byte |
| ports_weak | output | 1 | Ports 1-3 held by weak pull-ups only |
| emu_active | output | 1 | Emulation mode active |

## Verification
Mode changes (R2, R3, R4, R5) become visible one edge after their inputs are sampled. The bench therefore drives inputs on a falling edge, lets one rising edge pass, and compares the outputs on the next falling edge. The stabilization exit is checked at exactly the STAB_CYC-th edge after the wake edge, with the edge before it checked as still asleep. Reset qualification is checked on the edge before the 24th sampled-high edge and on that edge itself. After a power-down reset there is one extra edge for the oscillator restart, and one more before the run state. `ram_wr_block` follows `rst_pin` within the same cycle, so it is sampled on the falling edge after the pin changes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_PD_STOP = 3'd2,
    ST_PD_WAKE = 3'd3,
    ST_PD_RSTW = 3'd4
  } pmc_state_e;

  typedef enum logic [1:0] {
    PM_NORM = 2'b00,
    PM_HIGH = 2'b01,
    PM_LOW  = 2'b10,
    PM_WEAK = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int CYC_LEN = 12,
  parameter int RST_MC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic osc_run,
  output logic rst_qual
);
  localparam int LIM = RST_MC * CYC_LEN;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!rst_pin) cnt_d = '0;
    else if (osc_run && cnt_q != CW'(LIM)) cnt_d = cnt_q + 1'b1;
    qual_d = rst_pin && (rst_qual || (osc_run && cnt_q == CW'(LIM - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rst_qual <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      rst_qual <= qual_d;
    end
  end

  // R1: the internal reset only rises after the pin was sampled high
  a_r1_rise_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_qual) |-> $past(rst_pin));
endmodule

// File: rtl/pmc_strap.sv
module pmc_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic int_rst,
  input  logic ale_in,
  input  logic psen_in,
  output logic emu
);
  logic rst_q, armed, armed_d, emu_d;

  always_comb begin
    armed_d = rst_pin ? (!ale_in && psen_in) : armed;
    emu_d   = emu;
    if (rst_q && !rst_pin) emu_d = int_rst && armed && !ale_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      armed <= 1'b0;
      emu   <= 1'b0;
    end else begin
      rst_q <= rst_pin;
      armed <= armed_d;
      emu   <= emu_d;
    end
  end

  // R8: emulation can only start at the release of a qualified reset
  a_r8_emu_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu) |-> $past(int_rst) && !$past(ale_in));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int NIRQ     = 6,
  parameter int NEXT     = 2,
  parameter int STAB_CYC = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            int_rst,
  input  logic            rst_pin,
  input  logic            emu,
  input  logic            idle_req,
  input  logic            pd_req,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NEXT-1:0] ext_int_n,
  input  logic [NEXT-1:0] ext_en,
  input  logic [NEXT-1:0] ext_lvl,
  output pmc_state_e      state
);
  localparam int SCW = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;

  pmc_state_e     state_d;
  logic [SCW-1:0] stab_q, stab_d;
  logic [NEXT-1:0] wake_vec;
  logic           wake_any, irq_any, stab_done;

  for (genvar i = 0; i < NEXT; i++) begin : g_wake
    assign wake_vec[i] = ext_en[i] && ext_lvl[i] && !ext_int_n[i];
  end

  assign wake_any  = |wake_vec;
  assign irq_any   = |(irq_pend & irq_en);
  assign stab_done = (stab_q == SCW'(STAB_CYC - 1));

  always_comb begin
    state_d = state;
    if (int_rst) begin
      state_d = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (!emu) begin
            if (pd_req)        state_d = ST_PD_STOP;
            else if (idle_req) state_d = ST_IDLE;
          end
        end
        ST_IDLE:    if (irq_any) state_d = ST_RUN;
        ST_PD_STOP: begin
          if (wake_any)     state_d = ST_PD_WAKE;
          else if (rst_pin) state_d = ST_PD_RSTW;
        end
        ST_PD_WAKE: if (!wake_any && stab_done) state_d = ST_RUN;
        ST_PD_RSTW: if (!rst_pin) state_d = ST_PD_STOP;
        default:    state_d = ST_RUN;
      endcase
    end
    stab_d = '0;
    if (state == ST_PD_WAKE) stab_d = stab_done ? stab_q : stab_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      stab_q <= '0;
    end else begin
      state  <= state_d;
      stab_q <= stab_d;
    end
  end

  // R4: a stopped chip stays stopped without a wake source
  a_r4_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD_STOP && !wake_any && !rst_pin && !int_rst) |=> state == ST_PD_STOP);
  // R3: idle persists without an enabled pending interrupt
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !irq_any && !int_rst) |=> state == ST_IDLE);
  // R5: leaving the wake state toward run requires the count to be done
  a_r5_wake_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_PD_WAKE && state == ST_RUN && !$past(int_rst)) |-> $past(stab_done));
  // R2: power down takes priority over idle
  a_r2_pd_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && pd_req && !emu && !int_rst) |=> state == ST_PD_STOP);
endmodule

// File: rtl/pmc_pinmux.sv
module pmc_pinmux
  import pmc_pkg::*;
(
  input  pmc_state_e state,
  input  logic       emu,
  input  logic       ext_code,
  input  logic       rst_pin,
  input  logic       int_rst,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       ram_wr_block,
  output logic [1:0] ale_mode,
  output logic [1:0] psen_mode,
  output logic       p0_float,
  output logic       p2_addr,
  output logic       ports_weak
);
  logic      in_idle, in_pd;
  pin_mode_e strobe_mode;

  assign in_idle = (state == ST_IDLE);
  assign in_pd   = (state == ST_PD_STOP) || (state == ST_PD_WAKE) || (state == ST_PD_RSTW);

  always_comb begin
    if (emu)          strobe_mode = PM_WEAK;
    else if (in_idle) strobe_mode = PM_HIGH;
    else if (in_pd)   strobe_mode = PM_LOW;
    else              strobe_mode = PM_NORM;
  end

  assign cpu_clk_en    = (state == ST_RUN);
  assign periph_clk_en = (state == ST_RUN) || in_idle;
  assign osc_en        = (state != ST_PD_STOP);
  assign ram_wr_block  = in_idle && rst_pin && !int_rst;
  assign ale_mode      = strobe_mode;
  assign psen_mode     = strobe_mode;
  assign p0_float      = emu || ((in_idle || in_pd) && ext_code);
  assign p2_addr       = !emu && in_idle && ext_code;
  assign ports_weak    = emu;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NIRQ     = 6,
  parameter int NEXT     = 2,
  parameter int CYC_LEN  = 12,
  parameter int RST_MC   = 2,
  parameter int STAB_CYC = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin,
  input  logic            idle_req,
  input  logic            pd_req,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NEXT-1:0] ext_int_n,
  input  logic [NEXT-1:0] ext_en,
  input  logic [NEXT-1:0] ext_lvl,
  input  logic            ext_code,
  input  logic            ale_in,
  input  logic            psen_in,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            osc_en,
  output logic            int_rst,
  output logic            ram_wr_block,
  output logic [1:0]      ale_mode,
  output logic [1:0]      psen_mode,
  output logic            p0_float,
  output logic            p2_addr,
  output logic            ports_weak,
  output logic            emu_active
);
  pmc_state_e state;

  pmc_rst_qual #(.CYC_LEN(CYC_LEN), .RST_MC(RST_MC)) u_rq (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .osc_run(osc_en), .rst_qual(int_rst));

  pmc_strap u_strap (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .int_rst(int_rst),
    .ale_in(ale_in), .psen_in(psen_in), .emu(emu_active));

  pmc_fsm #(.NIRQ(NIRQ), .NEXT(NEXT), .STAB_CYC(STAB_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .int_rst(int_rst), .rst_pin(rst_pin), .emu(emu_active),
    .idle_req(idle_req), .pd_req(pd_req), .irq_pend(irq_pend), .irq_en(irq_en),
    .ext_int_n(ext_int_n), .ext_en(ext_en), .ext_lvl(ext_lvl), .state(state));

  pmc_pinmux u_pins (
    .state(state), .emu(emu_active), .ext_code(ext_code), .rst_pin(rst_pin),
    .int_rst(int_rst), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .ram_wr_block(ram_wr_block), .ale_mode(ale_mode),
    .psen_mode(psen_mode), .p0_float(p0_float), .p2_addr(p2_addr), .ports_weak(ports_weak));

  // R8: emulation never lets the oscillator stop
  a_r8_emu_osc: assert property (@(posedge clk) disable iff (!rst_n)
    emu_active |=> osc_en);
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int NIRQ = 6;
  localparam int NEXT = 2;
  localparam int STAB = 4;
  localparam int QLIM = 24;

  logic clk = 1'b0, rst_n, rst_pin, idle_req, pd_req, ext_code, ale_in, psen_in;
  logic [NIRQ-1:0] irq_pend, irq_en;
  logic [NEXT-1:0] ext_int_n, ext_en, ext_lvl;
  logic cpu_clk_en, periph_clk_en, osc_en, int_rst, ram_wr_block;
  logic [1:0] ale_mode, psen_mode;
  logic p0_float, p2_addr, ports_weak, emu_active;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NIRQ(NIRQ), .NEXT(NEXT), .CYC_LEN(12), .RST_MC(2), .STAB_CYC(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .ext_int_n(ext_int_n), .ext_en(ext_en),
    .ext_lvl(ext_lvl), .ext_code(ext_code), .ale_in(ale_in), .psen_in(psen_in),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .int_rst(int_rst), .ram_wr_block(ram_wr_block), .ale_mode(ale_mode),
    .psen_mode(psen_mode), .p0_float(p0_float), .p2_addr(p2_addr),
    .ports_weak(ports_weak), .emu_active(emu_active));

  // inputs {idle, pd, irq0, ext0_n} ; expected {cpu, periph, osc, ale[1:0], p0f, p2a}
  localparam logic [10:0] VEC [0:9] = '{
    {4'b1001, 7'b0110111},
    {4'b0001, 7'b0110111},
    {4'b0011, 7'b1110000},
    {4'b1101, 7'b0001010},
    {4'b0011, 7'b0001010},
    {4'b0000, 7'b0011010},
    {4'b0000, 7'b0011010},
    {4'b0001, 7'b0011010},
    {4'b0001, 7'b0011010},
    {4'b0001, 7'b1110000}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2 idle entry";
      1: return "R3 idle holds";
      2: return "R3 idle exit";
      3: return "R4 pd entry";
      4: return "R4 pd ignores irq";
      5: return "R5 wake";
      6, 7, 8: return "R5 stabilizing";
      default: return "R5 exit";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clear_req();
    idle_req = 1'b0; pd_req = 1'b0; irq_pend = '0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; clear_req();
    irq_en = '1; ext_int_n = '1; ext_en = 2'b01; ext_lvl = 2'b01;
    ext_code = 1'b1; ale_in = 1'b1; psen_in = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(1);
    // reset state: run, oscillator on, strobes normal
    chk("R2 reset cpu_clk_en", cpu_clk_en, 1);
    chk("R1 reset int_rst", int_rst, 0);
    chk("R6 reset ale_mode", ale_mode, 2'b00);

    // vector table walk
    for (int i = 0; i < 10; i++) begin
      {idle_req, pd_req, irq_pend[0], ext_int_n[0]} = VEC[i][10:7];
      step(1);
      chk(vtag(i), {cpu_clk_en, periph_clk_en, osc_en, ale_mode, p0_float, p2_addr}, VEC[i][6:0]);
      chk("R6 psen follows ale", psen_mode, ale_mode);
    end
    clear_req(); ext_int_n = '1;

    // R3: disabled pending interrupt leaves idle untouched
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    irq_en = 6'b111101; irq_pend = 6'b000010; step(2);
    chk("R3 disabled irq ignored", cpu_clk_en, 0);
    irq_en = '1; step(1);
    chk("R3 enabled irq exits", cpu_clk_en, 1);
    clear_req();

    // R4: disabled line and edge-configured line do not wake
    pd_req = 1'b1; step(1); pd_req = 1'b0;
    ext_int_n = 2'b10; ext_lvl = 2'b00; step(2);
    chk("R4 edge-mode line no wake", osc_en, 0);
    ext_int_n = 2'b01; ext_lvl = 2'b11; step(2);
    chk("R4 disabled line no wake", osc_en, 0);
    ext_lvl = 2'b01;
    // R5: long low hold, exit one edge after release
    ext_int_n = 2'b00; step(8);
    chk("R5 held low stays down", cpu_clk_en, 0);
    chk("R5 held low osc on", osc_en, 1);
    ext_int_n = 2'b11; step(1);
    chk("R5 exit after release", cpu_clk_en, 1);

    // R1: short pulse then full qualification
    rst_pin = 1'b1; step(10); rst_pin = 1'b0; step(1);
    chk("R1 short pulse ignored", int_rst, 0);
    rst_pin = 1'b1; step(QLIM - 1);
    chk("R1 not yet qualified", int_rst, 0);
    step(1);
    chk("R1 qualified", int_rst, 1);
    rst_pin = 1'b0; step(1);
    chk("R1 release", int_rst, 0);

    // R7: internal code in idle
    ext_code = 1'b0; idle_req = 1'b1; step(1); idle_req = 1'b0;
    chk("R7 internal code p0/p2", {p0_float, p2_addr}, 2'b00);
    chk("R6 idle strobes high", ale_mode, 2'b01);
    ext_code = 1'b1;
    // R9: reset while idle blocks RAM writes until internal reset
    rst_pin = 1'b1; step(1);
    chk("R9 block active", ram_wr_block, 1);
    step(QLIM - 1);
    chk("R9 block ends at int_rst", {int_rst, ram_wr_block}, 2'b10);
    step(1);
    chk("R9 run after reset", cpu_clk_en, 1);
    rst_pin = 1'b0; step(1);

    // R10: reset out of power down
    pd_req = 1'b1; step(1); pd_req = 1'b0;
    chk("R10 pd osc off", osc_en, 0);
    rst_pin = 1'b1; step(1);
    chk("R10 osc restarts", {osc_en, cpu_clk_en}, 2'b10);
    step(QLIM - 1);
    chk("R10 not yet qualified", int_rst, 0);
    step(1);
    chk("R10 qualified", int_rst, 1);
    step(1);
    chk("R10 run", cpu_clk_en, 1);
    rst_pin = 1'b0; step(1);

    // R8: strap into emulation
    ale_in = 1'b0; psen_in = 1'b1; rst_pin = 1'b1; step(QLIM);
    rst_pin = 1'b0; step(1);
    chk("R8 emu entered", {emu_active, ale_mode, p0_float, ports_weak}, 5'b11111);
    pd_req = 1'b1; step(1); pd_req = 1'b0; step(1);
    chk("R8 pd ignored", {osc_en, cpu_clk_en}, 2'b11);
    ale_in = 1'b1; rst_pin = 1'b1; step(QLIM); rst_pin = 1'b0; step(1);
    chk("R8 normal reset clears", {emu_active, ale_mode}, 3'b000);
    // R8: strap lost when ALE rises before release
    ale_in = 1'b0; rst_pin = 1'b1; step(QLIM); ale_in = 1'b1; step(1);
    rst_pin = 1'b0; step(1);
    chk("R8 no emu if ALE high at release", emu_active, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule